// File: doc/BRIEF.md
# Banked Register Command Slave over SPI

This block is a serial-bus target that gives a host processor access to a control register space and to a byte-wide packet buffer. The host sends one command byte per transaction. The upper three bits of that byte select the operation and the lower five bits select a register. The block decodes the command and then reads or updates a register, or streams bytes to or from the buffer memory through two pointers. Those pointers advance on their own and wrap inside a receive ring.

The register space has four banks. Two select bits in a control register choose the bank. The five highest addresses are shared: they reach the same registers from every bank, so the host can always reach interrupt, status and control state without switching banks. Bit-set and bit-clear commands change single flags without a read-modify-write sequence. Registers of the slow class return a dummy byte before their data.

The serial inputs are synchronised into the core clock domain. The status register reflects a side input driven by internal logic. The buffer memory sits outside the block and has a registered read port.

Top module: `spi_cmd_slave`

## Requirements
- R1: The command byte carries the opcode in bits [7:5] and the register address in bits [4:0]. The opcodes are: 000 register read, 001 buffer read, 010 register write, 011 buffer write, 100 bit-set, 101 bit-clear, 111 soft reset.
- R2: For addresses 0x00–0x1A, bits [1:0] of control register 1 (address 0x1F) select one of four independent banks.
- R3: Addresses 0x1B–0x1F reach the same registers in every bank: 0x1B interrupt enable, 0x1C interrupt flags, 0x1D status, 0x1E control 2, 0x1F control 1. Status is read-only and returns the `stat_in` port; writes to it are ignored.
- R4: Bit-set ORs the data byte into the addressed register. Bit-clear ANDs the register with the complement of the data byte.
- R5: In the slow class, a read returns one dummy byte of 0x00 before the data. The slow class is bank 2 addresses 0x00–0x1A, and bank 3 addresses 0x00–0x05 and 0x0A. All other reads return data in the first byte after the command.
- R6: The read pointer sits at bank 0 addresses 0x00 (low) and 0x01 (high). The write pointer sits at 0x02 (low) and 0x03 (high). Each pointer is 13 bits wide, so its high byte keeps bits [4:0] and reads 0 in bits [7:5]. The same masking applies at 0x09 and 0x0B.
- R7: When control 2 bit 7 is set, each buffer byte transferred advances the active pointer by one. When that bit is clear, the pointer stays put.
- R8: The ring start is held at bank 0 addresses 0x08/0x09 and the ring end at 0x0A/0x0B. A pointer that advances from the ring end goes to the ring start.
- R9: The soft-reset command returns every writable register to zero, including the bank select bits and the pointers.
- R10: Bank 3 address 0x12 returns the fixed revision value 0x06, and writes to it are ignored.
- R11: Deasserting chip-select ends any stream and clears the bit counter. The next byte is decoded as a command, and a partly shifted byte has no effect.
- R12: After reset every register reads zero and `spi_miso` is low.
- R13: The block uses mode 0. It samples MOSI on the rising SCLK edge and changes MISO only after falling edges. Read data starts with its MSB on the byte that follows the command or the dummy byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip-select that frames a transaction |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| stat_in | input | 8 | Internal status value returned at address 0x1D |
| mem_addr | output | 13 | Buffer memory byte address |
| mem_wdata | output | 8 | Buffer memory write data |
| mem_we | output | 1 | Buffer memory write strobe |
| mem_re | output | 1 | Buffer memory read strobe; data is due one clock later |
| mem_rdata | input | 8 | Buffer memory read data |

## Verification
The core sees an SCLK edge three clocks after the pin moves: two synchroniser stages plus the edge register. A completed byte is decoded one clock after its eighth rising edge. The reply byte, or the memory read it needs, enters the shift register two clocks after that. A buffer write lands in memory in the same clock as the decode. The bench holds each SCLK phase for eight core clocks and samples MISO just before it raises SCLK, so every reply has had at least ten clocks to settle. It reads register and pointer effects back only after chip-select has been released, and it inspects its own memory model only after the stream has ended.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [2:0] {
        OP_RD_REG = 3'b000,
        OP_RD_BUF = 3'b001,
        OP_WR_REG = 3'b010,
        OP_WR_BUF = 3'b011,
        OP_BIT_SET = 3'b100,
        OP_BIT_CLR = 3'b101,
        OP_UNUSED = 3'b110,
        OP_SRESET = 3'b111
    } op_e;

    typedef enum logic [3:0] {
        ST_CMD,
        ST_DUMMY,
        ST_RD_REG,
        ST_RD_BUF,
        ST_WR_REG,
        ST_BIT_SET,
        ST_BIT_CLR,
        ST_WR_BUF,
        ST_SKIP
    } st_e;

    localparam int BSEL_W   = 2;
    localparam int NBANK    = 2 ** BSEL_W;
    localparam int BANKED_N = 27;

    localparam logic [4:0] A_INT_EN  = 5'h1B;
    localparam logic [4:0] A_INT_FLG = 5'h1C;
    localparam logic [4:0] A_STATUS  = 5'h1D;
    localparam logic [4:0] A_CTRL2   = 5'h1E;
    localparam logic [4:0] A_CTRL1   = 5'h1F;
    localparam logic [4:0] A_REV     = 5'h12;

    localparam int P_RD    = 0;
    localparam int P_WR    = 2;
    localparam int P_RSTRT = 8;
    localparam int P_REND  = 10;

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
    parameter int              STAGES  = 2,
    parameter int              W       = 3,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[i] <= RST_VAL;
                else        stg_q[i] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[i] <= RST_VAL;
                else        stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_i,
    input  logic         cs_n_i,
    input  logic         mosi_i,
    input  logic         load_i,
    input  logic [W-1:0] load_byte_i,
    output logic         byte_done_o,
    output logic [W-1:0] rx_byte_o,
    output logic         miso_o
);
    localparam int CNT_W = $clog2(W);

    typedef struct packed {
        logic             sclk_p;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     rx;
        logic [W-1:0]     tx;
        logic             done;
        logic [W-1:0]     rxb;
    } shf_t;

    shf_t q, d;
    logic rise, fall;

    assign rise = sclk_i & ~q.sclk_p;
    assign fall = ~sclk_i & q.sclk_p;

    always_comb begin
        d        = q;
        d.sclk_p = sclk_i;
        d.done   = 1'b0;
        if (cs_n_i) begin
            d.cnt = '0;
            d.rx  = '0;
            d.tx  = '0;
        end else begin
            if (rise) begin
                d.rx  = {q.rx[W-2:0], mosi_i};
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(W - 1)) begin
                    d.done = 1'b1;
                    d.rxb  = {q.rx[W-2:0], mosi_i};
                    d.cnt  = '0;
                end
            end
            if (fall && q.cnt != '0) d.tx = {q.tx[W-2:0], 1'b0};
            if (load_i) d.tx = load_byte_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_done_o = q.done;
    assign rx_byte_o   = q.rxb;
    assign miso_o      = q.tx[W-1];

    // R11
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> (q.cnt == '0 && !q.done));

    // R13
    miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !cs_n_i) |=> $stable(miso_o));
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
    import spi_cmd_pkg::*;
#(
    parameter int         PTR_W       = 13,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] REV_ID      = 8'h06
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_sclk,
    input  logic             spi_cs_n,
    input  logic             spi_mosi,
    output logic             spi_miso,
    input  logic [7:0]       stat_in,
    output logic [PTR_W-1:0] mem_addr,
    output logic [7:0]       mem_wdata,
    output logic             mem_we,
    output logic             mem_re,
    input  logic [7:0]       mem_rdata
);
    localparam int         HI_W    = PTR_W - 8;
    localparam logic [7:0] HI_MASK = 8'((16'd1 << HI_W) - 16'd1);

    typedef struct packed {
        st_e                               st;
        logic [BSEL_W-1:0]                 bank;
        logic [4:0]                        addr;
        logic                              ld;
        logic                              ld_mem;
        logic [7:0]                        ld_val;
        logic [7:0]                        ie;
        logic [7:0]                        ifl;
        logic [7:0]                        c2;
        logic [7:0]                        c1;
        logic [NBANK-1:0][BANKED_N-1:0][7:0] arr;
    } core_t;

    core_t q, d;

    logic       sclk_s, cs_n_s, mosi_s;
    logic       byte_done;
    logic [7:0] rx_byte;
    logic [7:0] load_byte;

    spi_cmd_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({spi_sclk, spi_cs_n, spi_mosi}),
        .q_o   ({sclk_s, cs_n_s, mosi_s})
    );

    assign load_byte = q.ld_mem ? mem_rdata : q.ld_val;

    spi_cmd_shift #(.W(8)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk_s),
        .cs_n_i      (cs_n_s),
        .mosi_i      (mosi_s),
        .load_i      (q.ld),
        .load_byte_i (load_byte),
        .byte_done_o (byte_done),
        .rx_byte_o   (rx_byte),
        .miso_o      (spi_miso)
    );

    function automatic logic [PTR_W-1:0] get_ptr(core_t s, int lo);
        return {s.arr[0][lo+1][HI_W-1:0], s.arr[0][lo]};
    endfunction

    function automatic core_t set_ptr(core_t s, int lo, logic [PTR_W-1:0] p);
        core_t r = s;
        r.arr[0][lo]   = p[7:0];
        r.arr[0][lo+1] = 8'(p[PTR_W-1:8]);
        return r;
    endfunction

    function automatic logic is_slow(logic [BSEL_W-1:0] b, logic [4:0] a);
        if (a >= 5'(BANKED_N)) return 1'b0;
        if (b == 2'd2) return 1'b1;
        return (b == 2'd3) && (a <= 5'h05 || a == 5'h0A);
    endfunction

    function automatic logic [7:0] rd_reg(core_t s, logic [BSEL_W-1:0] b, logic [4:0] a,
                                          logic [7:0] st_v);
        if (a >= 5'(BANKED_N)) begin
            case (a)
                A_INT_EN:  return s.ie;
                A_INT_FLG: return s.ifl;
                A_STATUS:  return st_v;
                A_CTRL2:   return s.c2;
                default:   return s.c1;
            endcase
        end
        if (b == 2'd3 && a == A_REV) return REV_ID;
        return s.arr[b][a];
    endfunction

    function automatic core_t wr_reg(core_t s, logic [BSEL_W-1:0] b, logic [4:0] a,
                                     logic [7:0] v);
        core_t r = s;
        if (a >= 5'(BANKED_N)) begin
            case (a)
                A_INT_EN:  r.ie  = v;
                A_INT_FLG: r.ifl = v;
                A_CTRL2:   r.c2  = v;
                A_CTRL1:   r.c1  = v;
                default:   ;
            endcase
        end else if (!(b == 2'd3 && a == A_REV)) begin
            if (b == 2'd0 && (a == 5'h01 || a == 5'h03 || a == 5'h09 || a == 5'h0B))
                r.arr[b][a] = v & HI_MASK;
            else
                r.arr[b][a] = v;
        end
        return r;
    endfunction

    logic [PTR_W-1:0] rd_ptr, wr_ptr, ring_lo, ring_hi;
    assign rd_ptr  = get_ptr(q, P_RD);
    assign wr_ptr  = get_ptr(q, P_WR);
    assign ring_lo = get_ptr(q, P_RSTRT);
    assign ring_hi = get_ptr(q, P_REND);

    function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p, logic inc,
                                              logic [PTR_W-1:0] lo, logic [PTR_W-1:0] hi);
        if (!inc)    return p;
        if (p == hi) return lo;
        return p + 1'b1;
    endfunction

    always_comb begin
        logic [PTR_W-1:0] nxt;
        d         = q;
        d.ld      = 1'b0;
        mem_addr  = '0;
        mem_wdata = rx_byte;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        nxt       = '0;
        if (cs_n_s) begin
            d.st = ST_CMD;
        end else if (byte_done) begin
            case (q.st)
                ST_CMD: begin
                    d.addr = rx_byte[4:0];
                    d.bank = q.c1[BSEL_W-1:0];
                    case (op_e'(rx_byte[7:5]))
                        OP_RD_REG: begin
                            d.ld     = 1'b1;
                            d.ld_mem = 1'b0;
                            if (is_slow(q.c1[BSEL_W-1:0], rx_byte[4:0])) begin
                                d.ld_val = 8'h00;
                                d.st     = ST_DUMMY;
                            end else begin
                                d.ld_val = rd_reg(q, q.c1[BSEL_W-1:0], rx_byte[4:0], stat_in);
                                d.st     = ST_RD_REG;
                            end
                        end
                        OP_RD_BUF: begin
                            mem_re   = 1'b1;
                            mem_addr = rd_ptr;
                            d.ld     = 1'b1;
                            d.ld_mem = 1'b1;
                            d.st     = ST_RD_BUF;
                        end
                        OP_WR_REG:  d.st = ST_WR_REG;
                        OP_WR_BUF:  d.st = ST_WR_BUF;
                        OP_BIT_SET: d.st = ST_BIT_SET;
                        OP_BIT_CLR: d.st = ST_BIT_CLR;
                        OP_SRESET: begin
                            d    = core_t'('0);
                            d.st = ST_SKIP;
                        end
                        default: d.st = ST_SKIP;
                    endcase
                end
                ST_DUMMY, ST_RD_REG: begin
                    d.ld     = 1'b1;
                    d.ld_mem = 1'b0;
                    d.ld_val = rd_reg(q, q.bank, q.addr, stat_in);
                    d.st     = ST_RD_REG;
                end
                ST_RD_BUF: begin
                    nxt      = step(rd_ptr, q.c2[7], ring_lo, ring_hi);
                    d        = set_ptr(d, P_RD, nxt);
                    mem_re   = 1'b1;
                    mem_addr = nxt;
                    d.ld     = 1'b1;
                    d.ld_mem = 1'b1;
                end
                ST_WR_BUF: begin
                    mem_we   = 1'b1;
                    mem_addr = wr_ptr;
                    d        = set_ptr(d, P_WR, step(wr_ptr, q.c2[7], ring_lo, ring_hi));
                end
                ST_WR_REG: begin
                    d    = wr_reg(d, q.bank, q.addr, rx_byte);
                    d.st = ST_SKIP;
                end
                ST_BIT_SET: begin
                    d    = wr_reg(d, q.bank, q.addr, rd_reg(q, q.bank, q.addr, stat_in) | rx_byte);
                    d.st = ST_SKIP;
                end
                ST_BIT_CLR: begin
                    d    = wr_reg(d, q.bank, q.addr, rd_reg(q, q.bank, q.addr, stat_in) & ~rx_byte);
                    d.st = ST_SKIP;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R6
    ptr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.arr[0][1] & ~HI_MASK) == 8'h00 && (q.arr[0][3] & ~HI_MASK) == 8'h00);

    // R7
    no_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !q.c2[7]) |=> $stable(wr_ptr));

    // R8
    ring_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && q.c2[7] && mem_addr == ring_hi) |=> (wr_ptr == ring_lo));

    // R9
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !cs_n_s && q.st == ST_CMD && rx_byte == 8'hFF)
        |=> (q.c1 == 8'h00 && q.c2 == 8'h00 && q.ie == 8'h00 && wr_ptr == '0));

    // R11
    cs_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (q.st == ST_CMD && !mem_we));
endmodule

// File: tb/sim_spi_cmd_slave.sv
`timescale 1ns/1ps
module sim_spi_cmd_slave;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        miso;
    logic [7:0]  stat_in = 8'h00;
    logic [12:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_we, mem_re;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    spi_cmd_slave u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .stat_in(stat_in), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    logic [7:0] bmem [0:2047];
    always @(posedge clk) begin
        if (mem_we) bmem[mem_addr[10:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= bmem[mem_addr[10:0]];
    end

    logic [7:0] m_arr [4][27];
    logic [7:0] m_ie, m_if, m_c2, m_c1;

    function automatic void mdl_clear();
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < 27; a++) m_arr[b][a] = 8'h00;
        m_ie = 0; m_if = 0; m_c2 = 0; m_c1 = 0;
    endfunction

    function automatic logic slow(int b, int a);
        if (a >= 27) return 0;
        return (b == 2) || (b == 3 && (a <= 5 || a == 10));
    endfunction

    function automatic logic [7:0] exp_rd(int b, int a);
        case (a)
            27: return m_ie;
            28: return m_if;
            29: return stat_in;
            30: return m_c2;
            31: return m_c1;
            default: ;
        endcase
        if (b == 3 && a == 18) return 8'h06;
        return m_arr[b][a];
    endfunction

    function automatic void mdl_wr(int b, int a, logic [7:0] v);
        case (a)
            27: m_ie = v;
            28: m_if = v;
            29: ;
            30: m_c2 = v;
            31: m_c1 = v;
            default: begin
                if (b == 3 && a == 18) ;
                else if (b == 0 && (a == 1 || a == 3 || a == 9 || a == 11)) m_arr[b][a] = v & 8'h1F;
                else m_arr[b][a] = v;
            end
        endcase
    endfunction

    function automatic int cur_bank();
        return int'(m_c1[1:0]);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xb(input logic [7:0] t, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            mosi = t[i];
            repeat (HALF) @(negedge clk);
            r[i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic op2(input logic [7:0] c, input logic [7:0] v);
        logic [7:0] dm;
        cs_lo(); xb(c, dm); xb(v, dm); cs_hi();
    endtask

    task automatic reg_wr(input int a, input logic [7:0] v);
        op2(8'h40 | 8'(a), v);
        mdl_wr(cur_bank(), a, v);
    endtask

    task automatic reg_set(input int a, input logic [7:0] v);
        int b = cur_bank();
        logic [7:0] o = exp_rd(b, a);
        op2(8'h80 | 8'(a), v);
        mdl_wr(b, a, o | v);
    endtask

    task automatic reg_clr(input int a, input logic [7:0] v);
        int b = cur_bank();
        logic [7:0] o = exp_rd(b, a);
        op2(8'hA0 | 8'(a), v);
        mdl_wr(b, a, o & ~v);
    endtask

    task automatic reg_rd(input int a, output logic [7:0] v, output logic [7:0] dm);
        logic [7:0] junk;
        cs_lo();
        xb(8'(a), junk);
        dm = 8'h00;
        if (slow(cur_bank(), a)) xb(8'h00, dm);
        xb(8'h00, v);
        cs_hi();
    endtask

    task automatic rd_chk(input int a, input string tag);
        logic [7:0] v, dm;
        reg_rd(a, v, dm);
        chk(tag, {8'h00, v}, {8'h00, exp_rd(cur_bank(), a)});
    endtask

    task automatic sel_bank(input int b);
        reg_wr(31, 8'(b));
    endtask

    task automatic set_ptr(input int lo, input logic [12:0] p);
        reg_wr(lo, p[7:0]);
        reg_wr(lo + 1, {3'b000, p[12:8]});
    endtask

    task automatic buf_wr(input int n, input logic [7:0] base);
        logic [7:0] dm;
        cs_lo();
        xb(8'h7A, dm);
        for (int i = 0; i < n; i++) xb(base + 8'(i * 17), dm);
        cs_hi();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, dm, got;
        logic [7:0] rdv [4];
        void'($urandom(32'h5EED_0042));
        mdl_clear();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R12: reset state
        chk("R12 miso idle", {15'h0, miso}, 16'h0);
        rd_chk(31, "R12 ctrl1 reset");
        rd_chk(30, "R12 ctrl2 reset");
        rd_chk(5, "R12 bank0 reg reset");

        // R10 / R13: revision id, fast read, first byte valid
        sel_bank(3);
        rd_chk(18, "R10 R13 revision id");
        reg_wr(18, 8'h00);
        rd_chk(18, "R10 revision write ignored");

        // R5: slow class dummy byte
        reg_wr(10, 8'h3C);
        reg_rd(10, v, dm);
        chk("R5 dummy byte bank3", {8'h0, dm}, 16'h0000);
        chk("R5 slow data bank3", {8'h0, v}, 16'h003C);
        sel_bank(2);
        reg_wr(4, 8'h77);
        reg_rd(4, v, dm);
        chk("R5 dummy byte bank2", {8'h0, dm}, 16'h0000);
        chk("R5 slow data bank2", {8'h0, v}, 16'h0077);
        sel_bank(1);
        reg_wr(4, 8'h99);
        rd_chk(4, "R5 fast read bank1");

        // R2: banks are independent
        reg_wr(5, 8'h11);
        sel_bank(0);
        reg_wr(5, 8'h22);
        rd_chk(5, "R2 bank0 value");
        sel_bank(1);
        rd_chk(5, "R2 bank1 value");

        // R3: shared registers and read-only status
        sel_bank(0);
        reg_wr(27, 8'h5A);
        sel_bank(2);
        rd_chk(27, "R3 shared int enable");
        stat_in = 8'hC3;
        rd_chk(29, "R3 status reflects input");
        reg_wr(29, 8'h00);
        rd_chk(29, "R3 status write ignored");

        // R4 / R1: set and clear
        sel_bank(1);
        reg_wr(6, 8'hF0);
        reg_set(6, 8'h05);
        rd_chk(6, "R4 R1 bit set");
        reg_clr(6, 8'h30);
        rd_chk(6, "R4 R1 bit clear");

        // R6: pointer high byte masking
        sel_bank(0);
        reg_wr(1, 8'hFF);
        rd_chk(1, "R6 pointer high mask");

        // R7 / R8: buffer write with auto-increment and ring wrap
        set_ptr(8, 13'h0010);
        set_ptr(10, 13'h0102);
        set_ptr(2, 13'h0100);
        reg_set(30, 8'h80);
        buf_wr(5, 8'hD0);
        chk("R7 buf write 0", {8'h0, bmem[11'h100]}, {8'h0, 8'hD0});
        chk("R7 buf write 2", {8'h0, bmem[11'h102]}, {8'h0, 8'hD0 + 8'd34});
        chk("R8 wrap write 3", {8'h0, bmem[11'h010]}, {8'h0, 8'hD0 + 8'd51});
        chk("R8 wrap write 4", {8'h0, bmem[11'h011]}, {8'h0, 8'hD0 + 8'd68});
        mdl_wr(0, 2, 8'h12); mdl_wr(0, 3, 8'h00);
        rd_chk(2, "R8 write pointer low after wrap");
        rd_chk(3, "R6 write pointer high after wrap");

        // R7 / R8: buffer read stream
        set_ptr(0, 13'h0101);
        cs_lo();
        xb(8'h3A, dm);
        for (int i = 0; i < 4; i++) xb(8'h00, rdv[i]);
        cs_hi();
        chk("R7 buf read 0", {8'h0, rdv[0]}, {8'h0, 8'hD0 + 8'd17});
        chk("R7 buf read 1", {8'h0, rdv[1]}, {8'h0, 8'hD0 + 8'd34});
        chk("R8 buf read wrap", {8'h0, rdv[2]}, {8'h0, 8'hD0 + 8'd51});
        chk("R8 buf read 3", {8'h0, rdv[3]}, {8'h0, 8'hD0 + 8'd68});
        mdl_wr(0, 0, 8'h12); mdl_wr(0, 1, 8'h00);
        rd_chk(0, "R7 read pointer after stream");

        // R7: auto-increment off
        reg_clr(30, 8'h80);
        set_ptr(2, 13'h0020);
        buf_wr(3, 8'hE0);
        chk("R7 no-increment last byte wins", {8'h0, bmem[11'h020]}, {8'h0, 8'hE0 + 8'd34});
        rd_chk(2, "R7 pointer unchanged");

        // R11: chip-select aborts a stream mid-byte
        reg_set(30, 8'h80);
        set_ptr(2, 13'h0030);
        cs_lo();
        xb(8'h7A, dm);
        xb(8'h81, dm);
        for (int i = 0; i < 4; i++) begin
            mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        cs_hi();
        chk("R11 streamed byte stored", {8'h0, bmem[11'h030]}, 16'h0081);
        mdl_wr(0, 2, 8'h31);
        rd_chk(2, "R11 partial byte ignored");
        rd_chk(31, "R11 decoder expects command");

        // R9: soft reset
        reg_wr(27, 8'h55);
        sel_bank(2);
        cs_lo(); xb(8'hFF, dm); cs_hi();
        mdl_clear();
        rd_chk(31, "R9 ctrl1 cleared");
        rd_chk(27, "R9 int enable cleared");
        rd_chk(30, "R9 ctrl2 cleared");
        rd_chk(2, "R9 write pointer cleared");

        // Random register traffic against the model (R1 R2 R3 R4 R5)
        for (int k = 0; k < 70; k++) begin
            int b, a, op;
            logic [7:0] val;
            b   = int'($urandom_range(0, 3));
            a   = int'($urandom_range(0, 30));
            op  = int'($urandom_range(0, 2));
            val = 8'($urandom);
            stat_in = 8'($urandom);
            sel_bank(b);
            case (op)
                0: reg_wr(a, val);
                1: reg_set(a, val);
                default: reg_clr(a, val);
            endcase
            reg_rd(a, got, dm);
            chk($sformatf("R1 R2 R4 random b%0d a%0h", b, a), {8'h0, got}, {8'h0, exp_rd(b, a)});
            if (slow(b, a)) chk("R5 random dummy", {8'h0, dm}, 16'h0000);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule